// File: doc/BRIEF.md
# Packet Statistics Counter Bank with Coherent Snapshot

This block watches one transmit and one receive packet stream. For each direction it counts start-of-packet beats, end-of-packet beats and packets that end with an error flag. Each of the six counters is 64 bits wide.

Software reads a counter as two 32-bit words over a simple register port. A 64-bit value cannot be read in one access, so the block keeps a shadow copy of every counter. One control write copies all six live counters into their shadows in the same cycle. Reads then return the frozen copy while the live counters keep running. As a result, both halves of one counter agree with each other, and all six counters show the same instant.

Separate control bits empty the shadow copy and zero the live counters.

Top module: `pkt_stat_bank`

## Requirements
- R1: A beat with valid high and its start marker set adds one to that direction's SOP counter. A beat with valid high and its end marker set adds one to the EOP counter. A beat with valid, end marker and error flag all high adds one to the error counter. The counter order is tx SOP, tx EOP, tx error, rx SOP, rx EOP, rx error.
- R2: Counter k (k = 0..5, in the R1 order) reads its low 32 bits at byte address 0x10 + 8k and its high 32 bits at 0x10 + 8k + 4.
- R3: Writing 1 to bit 0 of the control word at address 0x00 copies all six live counters into the shadow set in one cycle. Counter reads return only the shadow values, and the live counters keep counting while a copy is held.
- R4: Reading address 0x00 returns the snapshot-available flag in bit 0, with all other bits 0. A capture sets this flag.
- R5: Writing 1 to control bit 1 zeroes every shadow value and drops the flag. When bits 0 and 1 are written together, bit 1 wins. A control write with both bits at 0 changes nothing.
- R6: Writing 1 to control bit 2 zeroes all live counters. If an increment falls in the same cycle, the counter still ends at zero.
- R7: After reset, all live counters, all shadow values and the flag are zero.
- R8: The valid signal gates every count. An error flag without an end marker is not counted.
- R9: Reads of addresses outside the control word and the twelve counter words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_valid_i | input | 1 | Transmit beat valid |
| tx_sop_i | input | 1 | Transmit start-of-packet marker |
| tx_eop_i | input | 1 | Transmit end-of-packet marker |
| tx_err_i | input | 1 | Transmit error flag |
| rx_valid_i | input | 1 | Receive beat valid |
| rx_sop_i | input | 1 | Receive start-of-packet marker |
| rx_eop_i | input | 1 | Receive end-of-packet marker |
| rx_err_i | input | 1 | Receive error flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |

## Verification
The assertions check, on every cycle, the counting rules that can be stated from one edge to the next:
- each live counter steps by exactly its increment, or falls to zero on a clear;
- the shadow set holds still unless a capture or a shadow clear is written;
- a capture copies the live values and raises the flag;
- a shadow clear empties the set and drops the flag, even when a capture is written with it.

Only the bench scenarios show the following:
- the beat qualification (valid gating, and error counted only on end beats) as seen through the address map;
- the split of each value into low and high words at the right addresses;
- the freeze seen by software while traffic keeps flowing;
- zero reads from unmapped addresses.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;
  localparam int unsigned NUM_CTR = 6;

  typedef enum logic [2:0] {
    EV_TX_SOP = 3'd0,
    EV_TX_EOP = 3'd1,
    EV_TX_ERR = 3'd2,
    EV_RX_SOP = 3'd3,
    EV_RX_EOP = 3'd4,
    EV_RX_ERR = 3'd5
  } ev_idx_e;

  localparam int unsigned CTL_SNAP_BIT = 0;
  localparam int unsigned CTL_SCLR_BIT = 1;
  localparam int unsigned CTL_CCLR_BIT = 2;
endpackage

// File: rtl/pkt_stat_ctr.sv
module pkt_stat_ctr #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;  // clear beats same-cycle increment
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/pkt_stat_shadow.sv
module pkt_stat_shadow #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic                clr_i,
  input  logic [N-1:0][W-1:0] live_i,
  output logic [N-1:0][W-1:0] snap_o,
  output logic                vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_o <= '0;
      vld_o  <= 1'b0;
    end else if (clr_i) begin
      snap_o <= '0;
      vld_o  <= 1'b0;
    end else if (cap_i) begin
      snap_o <= live_i;
      vld_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/pkt_stat_rdmux.sv
module pkt_stat_rdmux #(
  parameter int unsigned N        = 6,
  parameter int unsigned W        = 64,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 8,
  parameter int unsigned CTL_ADDR = 0,
  parameter int unsigned CTR_BASE = 16
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [N-1:0][W-1:0] snap_i,
  input  logic                vld_i,
  output logic [DW-1:0]       rdata_o
);
  localparam int unsigned HI_W = W - DW;

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(CTL_ADDR)) rdata_o = {{(DW-1){1'b0}}, vld_i};
    for (int i = 0; i < int'(N); i++) begin
      if (addr_i == AW'(CTR_BASE + 8*i))
        rdata_o = snap_i[i][DW-1:0];
      if (addr_i == AW'(CTR_BASE + 8*i + 4))
        rdata_o = DW'(snap_i[i][W-1 -: HI_W]);
    end
  end
endmodule

// File: rtl/pkt_stat_bank.sv
module pkt_stat_bank
  import pkt_stat_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CTL_ADDR = 0,
  parameter int unsigned CTR_BASE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic              tx_sop_i,
  input  logic              tx_eop_i,
  input  logic              tx_err_i,
  input  logic              rx_valid_i,
  input  logic              rx_sop_i,
  input  logic              rx_eop_i,
  input  logic              rx_err_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic                          ctl_wr;
  logic                          snap_cap, snap_clr, cnt_clr;
  logic [NUM_CTR-1:0]            inc;
  logic [NUM_CTR-1:0][CNT_W-1:0] live;
  logic [NUM_CTR-1:0][CNT_W-1:0] snap;
  logic                          snap_vld;

  assign ctl_wr   = reg_we_i && (reg_addr_i == ADDR_W'(CTL_ADDR));
  assign snap_cap = ctl_wr && reg_wdata_i[CTL_SNAP_BIT];
  assign snap_clr = ctl_wr && reg_wdata_i[CTL_SCLR_BIT];
  assign cnt_clr  = ctl_wr && reg_wdata_i[CTL_CCLR_BIT];

  // beat qualification; error only counted on closing beat
  always_comb begin
    inc            = '0;
    inc[EV_TX_SOP] = tx_valid_i && tx_sop_i;
    inc[EV_TX_EOP] = tx_valid_i && tx_eop_i;
    inc[EV_TX_ERR] = tx_valid_i && tx_eop_i && tx_err_i;
    inc[EV_RX_SOP] = rx_valid_i && rx_sop_i;
    inc[EV_RX_EOP] = rx_valid_i && rx_eop_i;
    inc[EV_RX_ERR] = rx_valid_i && rx_eop_i && rx_err_i;
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    pkt_stat_ctr #(.W(CNT_W)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (cnt_clr),
      .inc_i (inc[g]),
      .cnt_o (live[g])
    );
  end

  pkt_stat_shadow #(.N(NUM_CTR), .W(CNT_W)) u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (snap_cap),
    .clr_i (snap_clr),
    .live_i(live),
    .snap_o(snap),
    .vld_o (snap_vld)
  );

  pkt_stat_rdmux #(
    .N(NUM_CTR), .W(CNT_W), .DW(DATA_W), .AW(ADDR_W),
    .CTL_ADDR(CTL_ADDR), .CTR_BASE(CTR_BASE)
  ) u_rdmux (
    .addr_i (reg_addr_i),
    .snap_i (snap),
    .vld_i  (snap_vld),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/pkt_stat_bank_chk.sv
module pkt_stat_bank_chk #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                snap_cap,
  input logic                snap_clr,
  input logic                cnt_clr,
  input logic [N-1:0]        inc,
  input logic [N-1:0][W-1:0] live,
  input logic [N-1:0][W-1:0] snap,
  input logic                snap_vld
);
  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_clr |=> live[g] == $past(live[g]) + W'($past(inc[g])));
    assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_clr |=> live[g] == '0);
  end

  assert_snap_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_cap && !snap_clr) |=> $stable(snap) && $stable(snap_vld));
  assert_snap_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_cap && !snap_clr) |=> snap == $past(live));
  assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_cap && !snap_clr) |=> snap_vld);
  assert_snap_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_clr |=> !snap_vld && snap == '0);
endmodule

bind pkt_stat_bank pkt_stat_bank_chk #(.N(pkt_stat_pkg::NUM_CTR), .W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .snap_cap(snap_cap),
  .snap_clr(snap_clr),
  .cnt_clr (cnt_clr),
  .inc     (inc),
  .live    (live),
  .snap    (snap),
  .snap_vld(snap_vld)
);

// File: tb/pkt_stat_bank_bench.sv
module pkt_stat_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_v = 0, tx_s = 0, tx_e = 0, tx_x = 0;
  logic        rx_v = 0, rx_s = 0, rx_e = 0, rx_x = 0;
  logic        we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int          tests = 0, fails = 0;
  logic [63:0] model [6];
  logic [63:0] held  [6];

  always #5 clk = ~clk;

  pkt_stat_bank u_pkt_stat_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_valid_i(tx_v), .tx_sop_i(tx_s), .tx_eop_i(tx_e), .tx_err_i(tx_x),
    .rx_valid_i(rx_v), .rx_sop_i(rx_s), .rx_eop_i(rx_e), .rx_err_i(rx_x),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // {tx valid,sop,eop,err}, {rx valid,sop,eop,err}, expected increment mask (bit k = counter k)
  localparam logic [13:0] VEC [12] = '{
    {4'b1100, 4'b0000, 6'b000001},
    {4'b1010, 4'b0000, 6'b000010},
    {4'b1011, 4'b0000, 6'b000110},
    {4'b1001, 4'b0000, 6'b000000},
    {4'b0111, 4'b0000, 6'b000000},
    {4'b1111, 4'b0000, 6'b000111},
    {4'b0000, 4'b1100, 6'b001000},
    {4'b0000, 4'b1011, 6'b110000},
    {4'b0000, 4'b0110, 6'b000000},
    {4'b0000, 4'b1101, 6'b001000},
    {4'b1110, 4'b1110, 6'b011011},
    {4'b1011, 4'b1111, 6'b111110}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_streams(input logic [3:0] t, input logic [3:0] r);
    {tx_v, tx_s, tx_e, tx_x} = t;
    {rx_v, rx_s, rx_e, rx_x} = r;
  endtask

  // one cycle: optional control write alongside stream beat
  task automatic cycle(input logic [3:0] t, input logic [3:0] r, input logic w, input logic [31:0] d);
    @(negedge clk);
    set_streams(t, r);
    we = w; addr = 8'h00; wdata = d;
    @(negedge clk);
    set_streams(4'b0, 4'b0);
    we = 1'b0; wdata = '0;
  endtask

  task automatic ctl(input logic [31:0] d);
    cycle(4'b0, 4'b0, 1'b1, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int k = 0; k < 6; k++) begin
      rd(8'h10 + 8'(8*k), v);
      check(req, v, model[k][31:0]);
      rd(8'h14 + 8'(8*k), v);
      check(req, v, model[k][63:32]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 6; k++) model[k] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    rd(8'h00, v); check("R7 flag", v, 32'h0);
    check_all("R7 counters");

    // table walk: R1 R8
    for (int i = 0; i < 12; i++) begin
      for (int n = 0; n < (i % 3) + 1; n++) begin
        cycle(VEC[i][13:10], VEC[i][9:6], 1'b0, '0);
        for (int k = 0; k < 6; k++) model[k] += 64'(VEC[i][k]);
      end
    end
    ctl(32'h1);
    rd(8'h00, v); check("R4 flag set", v, 32'h1);
    check_all("R1 R8 R2 counts");

    // R3 freeze while live counting continues
    for (int k = 0; k < 6; k++) held[k] = model[k];
    repeat (3) cycle(4'b1100, 4'b1010, 1'b0, '0);
    model[0] += 3; model[4] += 3;
    rd(8'h10, v); check("R3 frozen tx sop", v, held[0][31:0]);
    rd(8'h30, v); check("R3 frozen rx eop", v, held[4][31:0]);
    ctl(32'h1);
    rd(8'h10, v); check("R3 recapture tx sop", v, model[0][31:0]);
    rd(8'h30, v); check("R3 recapture rx eop", v, model[4][31:0]);

    // R5 no-op write, then shadow clear, then clear beats capture
    ctl(32'h0);
    rd(8'h00, v); check("R5 zero write flag", v, 32'h1);
    rd(8'h10, v); check("R5 zero write value", v, model[0][31:0]);
    ctl(32'h2);
    rd(8'h00, v); check("R5 clear flag", v, 32'h0);
    rd(8'h10, v); check("R5 clear value", v, 32'h0);
    rd(8'h30, v); check("R5 clear value rx", v, 32'h0);
    ctl(32'h3);
    rd(8'h00, v); check("R5 clear wins flag", v, 32'h0);
    rd(8'h10, v); check("R5 clear wins value", v, 32'h0);

    // R6 counter clear concurrent with increments
    cycle(4'b1111, 4'b1111, 1'b1, 32'h4);
    for (int k = 0; k < 6; k++) model[k] = '0;
    ctl(32'h1);
    check_all("R6 clear wins");
    cycle(4'b1100, 4'b0000, 1'b0, '0);
    model[0] = 1;
    ctl(32'h1);
    rd(8'h10, v); check("R6 resume count", v, 32'h1);

    // R9 unmapped addresses
    rd(8'h08, v); check("R9 gap", v, 32'h0);
    rd(8'h40, v); check("R9 above map", v, 32'h0);
    rd(8'h12, v); check("R9 unaligned", v, 32'h0);
    rd(8'h04, v); check("R9 near control", v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule